// File: doc/BRIEF.md
# Sequence-Number Code Invalidation Controller

This block keeps a cache of translated code consistent with later stores, without ever searching the cache for stale lines. Every page that may feed translated code carries a sequence number in a small page table, and every cache line of translated code carries the number of the page it came from. A store anywhere in a page clears that page's hot flag. From then on no line still holding the old number can match it, so the stale lines drop out by themselves as misses.

A sequence number has two fields: a 2-bit epoch and a count. Fresh numbers are always drawn from the epoch after the current one. A background sweep, run only in idle cycles that fetch misses pay for, moves the current epoch forward. It renumbers lines (and their pages) that are still valid and zeroes those that are not, so that old numbers can be reused. A direct-mapped reverse table, indexed by real page number, lets a store that carries only a real address find its page-table entry.

Four kinds of request share one priority arbiter: external store by real page, internal store by page index, fetch check, and page warm. The sweep runs only when none of them is present. The default parameters are 4 page entries, a 4-slot reverse table, 8 lines, a 3-bit count and 2 sweep steps bought by each fetch miss.

Top module: `code_seq_guard`

## Requirements
- R1: After reset, every page is cold, every line count is 0, the epoch output is 0 and the running maximum is 1. A fetch check of any line therefore misses.
- R2: Requests are served one per cycle, in this priority: external store, internal store, fetch check, warm, sweep step. A fetch or warm that loses arbitration gets no response.
- R3: Warming a page entry that is already hot for the same real page succeeds and changes no state.
- R4: Any other warm gets a fresh number {epoch+1, running maximum}, marks the entry hot with the given real page, and raises the maximum by 1. The fresh number is computed after any raise that R7 applies. A later fetch miss refills the line with that number, and the fetch after the refill hits.
- R5: An internal store to a hot entry makes it cold, so fetches through it miss.
- R6: An external store on real page p looks at the reverse-table slot p mod 4. It cools that slot's entry only if the entry is hot and holds real page p.
- R7: A warm that must assign a number takes the slot (real page mod 4) in the reverse table. It cools the previous occupant if that occupant is another hot entry. If the occupant's number is in epoch+1, the maximum is first raised to at least its count plus 1.
- R8: If the fresh count would reach 8 (the count space is 3 bits), the warm fails (ok=0) and changes nothing. Code from that page then runs uncached.
- R9: Cooling an entry whose number is in epoch+1 raises the running maximum to at least its count plus 1.
- R10: A fetch hits only if all of these hold: the entry is hot, the line records that entry and its real page, the counts are equal, and either the epochs are equal or the line is in the current epoch while the page is in the one before. On a miss to a hot entry, the line takes the page's number, index and real page.
- R11: A sweep pass starts on a sweep step when no pass is active. It adds 1 to the epoch modulo 4, sets the running maximum to 1 and begins at line 0. Each later step visits one line, and the pass ends after line 7.
- R12: A visited line whose epoch is the previous one and whose count is nonzero is kept if its page is still hot, has the same real page and count, and has an epoch that is previous or current. Both the line and the page then move to the current epoch. Any other such line gets count 0.
- R13: Each fetch miss adds 2 sweep steps to a budget that saturates at 15. A step runs only in a cycle with no other request and uses one unit of the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xs_vld | input | 1 | External store present |
| xs_rpn | input | 6 | Real page of the external store |
| is_vld | input | 1 | Internal store present |
| is_tlb | input | 2 | Page entry written by the internal store |
| fc_vld | input | 1 | Fetch check present |
| fc_line | input | 3 | Cache line being fetched |
| fc_tlb | input | 2 | Page entry the fetched code belongs to |
| wm_vld | input | 1 | Warm request present |
| wm_tlb | input | 2 | Page entry to warm |
| wm_rpn | input | 6 | Real page held by that entry |
| fc_rsp | output | 1 | A fetch check was served last cycle |
| fc_hit | output | 1 | The served fetch check hit |
| wm_rsp | output | 1 | A warm was served last cycle |
| wm_ok | output | 1 | The served warm succeeded |
| epoch | output | 2 | Current sweep epoch |

## Verification
Every fetch and warm result is registered: a request presented before a rising edge shows its response after that edge. The bench drives on the falling edge and compares one half period after the edge. Stores act on that same edge, so the earliest cycle that can see their effect is the request presented at the next falling edge. A sweep step happens only in a cycle with no request, and the epoch moves on the edge of the idle cycle that starts a pass. The bench's reference model advances one step per clock to match, and each cycle's result is compared against the model before new inputs are applied.

// File: rtl/csg_pkg.sv
package csg_pkg;
  localparam int CYC_W = 2;
  typedef logic [CYC_W-1:0] cyc_t;

  // request slots of the arbiter, highest priority first
  localparam int G_XS   = 0;
  localparam int G_IS   = 1;
  localparam int G_FC   = 2;
  localparam int G_WM   = 3;
  localparam int G_CL   = 4;
  localparam int N_KIND = 5;

  function automatic cyc_t cyc_after(cyc_t c);
    return c + cyc_t'(1);
  endfunction

  function automatic cyc_t cyc_before(cyc_t c);
    return c - cyc_t'(1);
  endfunction
endpackage

// File: rtl/csg_arbiter.sv
module csg_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] & ~taken;
      taken  = taken | req[i];
    end
  end
endmodule

// File: rtl/csg_sweep.sv
module csg_sweep
  import csg_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int LW       = 3,
  parameter int BUDGET_W = 4,
  parameter int STEPS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add,
  input  logic          step,
  output logic          budget_nz,
  output logic          pass_start,
  output logic          line_step,
  output logic [LW-1:0] ptr,
  output cyc_t          epoch
);
  localparam int BMAX = (1 << BUDGET_W) - 1;

  logic                active;
  logic [BUDGET_W-1:0] budget;

  function automatic logic [BUDGET_W-1:0] sat_add(logic [BUDGET_W-1:0] b);
    int s;
    s = int'(b) + STEPS;
    return (s > BMAX) ? BUDGET_W'(BMAX) : BUDGET_W'(s);
  endfunction

  assign budget_nz  = (budget != '0);
  assign pass_start = step & ~active;
  assign line_step  = step & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget <= '0;
      active <= 1'b0;
      ptr    <= '0;
      epoch  <= '0;
    end else begin
      if (add)       budget <= sat_add(budget);
      else if (step) budget <= budget - BUDGET_W'(1);
      if (pass_start) begin
        epoch  <= cyc_after(epoch);
        ptr    <= '0;
        active <= 1'b1;
      end
      if (line_step) begin
        if (ptr == LW'(LINES - 1)) begin
          active <= 1'b0;
          ptr    <= '0;
        end else begin
          ptr <= ptr + LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/csg_line_store.sv
module csg_line_store #(
  parameter int LINES = 8,
  parameter int LW    = 3,
  parameter int SN_W  = 5,
  parameter int TW    = 2,
  parameter int RPN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    ra_idx,
  output logic [SN_W-1:0]  ra_sn,
  output logic [TW-1:0]    ra_tlb,
  output logic [RPN_W-1:0] ra_rpn,
  input  logic [LW-1:0]    rb_idx,
  output logic [SN_W-1:0]  rb_sn,
  output logic [TW-1:0]    rb_tlb,
  output logic [RPN_W-1:0] rb_rpn,
  input  logic             we_sn,
  input  logic             we_tag,
  input  logic [LW-1:0]    waddr,
  input  logic [SN_W-1:0]  wsn,
  input  logic [TW-1:0]    wtlb,
  input  logic [RPN_W-1:0] wrpn
);
  logic [SN_W-1:0]  sn_q  [LINES];
  logic [TW-1:0]    tlb_q [LINES];
  logic [RPN_W-1:0] rpn_q [LINES];

  assign ra_sn  = sn_q[ra_idx];
  assign ra_tlb = tlb_q[ra_idx];
  assign ra_rpn = rpn_q[ra_idx];
  assign rb_sn  = sn_q[rb_idx];
  assign rb_tlb = tlb_q[rb_idx];
  assign rb_rpn = rpn_q[rb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        sn_q[i]  <= '0;
        tlb_q[i] <= '0;
        rpn_q[i] <= '0;
      end
    end else begin
      if (we_sn) sn_q[waddr] <= wsn;
      if (we_tag) begin
        tlb_q[waddr] <= wtlb;
        rpn_q[waddr] <= wrpn;
      end
    end
  end
endmodule

// File: rtl/code_seq_guard.sv
module code_seq_guard
  import csg_pkg::*;
#(
  parameter int TLB_N    = 4,
  parameter int RT_N     = 4,
  parameter int LINES    = 8,
  parameter int CNT_W    = 3,
  parameter int RPN_W    = 6,
  parameter int STEPS    = 2,
  parameter int BUDGET_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xs_vld,
  input  logic [RPN_W-1:0]             xs_rpn,
  input  logic                         is_vld,
  input  logic [$clog2(TLB_N)-1:0]     is_tlb,
  input  logic                         fc_vld,
  input  logic [$clog2(LINES)-1:0]     fc_line,
  input  logic [$clog2(TLB_N)-1:0]     fc_tlb,
  input  logic                         wm_vld,
  input  logic [$clog2(TLB_N)-1:0]     wm_tlb,
  input  logic [RPN_W-1:0]             wm_rpn,
  output logic                         fc_rsp,
  output logic                         fc_hit,
  output logic                         wm_rsp,
  output logic                         wm_ok,
  output logic [CYC_W-1:0]             epoch
);
  localparam int TW    = $clog2(TLB_N);
  localparam int RW    = $clog2(RT_N);
  localparam int LW    = $clog2(LINES);
  localparam int SN_W  = CNT_W + CYC_W;
  localparam int MAX_W = CNT_W + 1;

  // ---------------- number arithmetic ----------------
  function automatic logic [CNT_W-1:0] cnt_of(logic [SN_W-1:0] s);
    return s[CNT_W-1:0];
  endfunction

  function automatic cyc_t cyc_of(logic [SN_W-1:0] s);
    return s[SN_W-1:CNT_W];
  endfunction

  function automatic logic line_matches(logic [SN_W-1:0] ls, logic [SN_W-1:0] ps, cyc_t cur);
    return (cnt_of(ls) == cnt_of(ps)) &&
           ((cyc_of(ls) == cyc_of(ps)) ||
            (cyc_of(ls) == cur && cyc_of(ps) == cyc_before(cur)));
  endfunction

  function automatic logic [MAX_W-1:0] raised_max(logic [MAX_W-1:0] m, logic [SN_W-1:0] s, cyc_t nxt);
    logic [MAX_W-1:0] bumped;
    bumped = {1'b0, cnt_of(s)} + MAX_W'(1);
    return (cyc_of(s) == nxt && bumped > m) ? bumped : m;
  endfunction

  // ---------------- page state ----------------
  logic [TLB_N-1:0] hot_q;
  logic [SN_W-1:0]  psn_q  [TLB_N];
  logic [RPN_W-1:0] prpn_q [TLB_N];
  logic [TW-1:0]    rt_q   [RT_N];
  logic [MAX_W-1:0] maxc_q;

  // ---------------- arbitration ----------------
  logic [N_KIND-1:0] req, gnt;
  logic              budget_nz, pass_start, line_step;
  logic [LW-1:0]     ptr;
  cyc_t              nxt, prv;

  assign req = {budget_nz, wm_vld, fc_vld, is_vld, xs_vld};

  csg_arbiter #(.N(N_KIND)) u_arb (.req(req), .gnt(gnt));

  assign nxt = cyc_after(epoch);
  assign prv = cyc_before(epoch);

  // ---------------- stores ----------------
  logic [RW-1:0] xs_slot;
  logic [TW-1:0] xs_tgt, chill_tgt;
  logic          xs_live, chill_en;

  assign xs_slot   = xs_rpn[RW-1:0];
  assign xs_tgt    = rt_q[xs_slot];
  assign xs_live   = hot_q[xs_tgt] && (prpn_q[xs_tgt] == xs_rpn);
  assign chill_en  = (gnt[G_XS] & xs_live) | (gnt[G_IS] & hot_q[is_tlb]);
  assign chill_tgt = gnt[G_XS] ? xs_tgt : is_tlb;

  // ---------------- fetch check ----------------
  logic [SN_W-1:0]  la_sn, lb_sn, f_page, s_page, line_wsn;
  logic [TW-1:0]    la_tlb, lb_tlb;
  logic [RPN_W-1:0] la_rpn, lb_rpn;
  logic             f_hit, f_miss, refill;

  assign f_page = psn_q[fc_tlb];
  assign f_hit  = hot_q[fc_tlb] && (la_tlb == fc_tlb) &&
                  (la_rpn == prpn_q[fc_tlb]) && line_matches(la_sn, f_page, epoch);
  assign f_miss = gnt[G_FC] & ~f_hit;
  assign refill = f_miss & hot_q[fc_tlb];

  // ---------------- warm ----------------
  logic [RW-1:0]    w_slot;
  logic [TW-1:0]    w_old;
  logic             w_same, w_vict, w_room, w_ok, w_take;
  logic [MAX_W-1:0] w_cand;

  assign w_same = hot_q[wm_tlb] && (prpn_q[wm_tlb] == wm_rpn);
  assign w_slot = wm_rpn[RW-1:0];
  assign w_old  = rt_q[w_slot];
  assign w_vict = ~w_same && (w_old != wm_tlb) && hot_q[w_old];
  assign w_cand = w_vict ? raised_max(maxc_q, psn_q[w_old], nxt) : maxc_q;
  assign w_room = ~w_cand[CNT_W];
  assign w_ok   = w_same | w_room;
  assign w_take = gnt[G_WM] & ~w_same & w_room;

  // ---------------- sweep ----------------
  logic s_visit, s_keep;

  csg_sweep #(.LINES(LINES), .LW(LW), .BUDGET_W(BUDGET_W), .STEPS(STEPS)) u_sweep (
    .clk(clk), .rst_n(rst_n), .add(f_miss), .step(gnt[G_CL]),
    .budget_nz(budget_nz), .pass_start(pass_start), .line_step(line_step),
    .ptr(ptr), .epoch(epoch)
  );

  assign s_page  = psn_q[lb_tlb];
  assign s_visit = line_step && (cyc_of(lb_sn) == prv) && (cnt_of(lb_sn) != '0);
  assign s_keep  = hot_q[lb_tlb] && (prpn_q[lb_tlb] == lb_rpn) &&
                   (cnt_of(s_page) == cnt_of(lb_sn)) &&
                   (cyc_of(s_page) == prv || cyc_of(s_page) == epoch);

  assign line_wsn = refill ? f_page :
                    s_keep ? {epoch, cnt_of(lb_sn)} : {cyc_of(lb_sn), CNT_W'(0)};

  csg_line_store #(.LINES(LINES), .LW(LW), .SN_W(SN_W), .TW(TW), .RPN_W(RPN_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(fc_line), .ra_sn(la_sn), .ra_tlb(la_tlb), .ra_rpn(la_rpn),
    .rb_idx(ptr), .rb_sn(lb_sn), .rb_tlb(lb_tlb), .rb_rpn(lb_rpn),
    .we_sn(refill | s_visit), .we_tag(refill),
    .waddr(refill ? fc_line : ptr), .wsn(line_wsn),
    .wtlb(fc_tlb), .wrpn(prpn_q[fc_tlb])
  );

  // ---------------- page state update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q  <= '0;
      maxc_q <= MAX_W'(1);
      for (int i = 0; i < TLB_N; i++) begin
        psn_q[i]  <= '0;
        prpn_q[i] <= '0;
      end
      for (int j = 0; j < RT_N; j++) rt_q[j] <= '0;
    end else begin
      if (chill_en) begin
        hot_q[chill_tgt] <= 1'b0;
        maxc_q           <= raised_max(maxc_q, psn_q[chill_tgt], nxt);
      end
      if (w_take) begin
        rt_q[w_slot] <= wm_tlb;
        if (w_vict) hot_q[w_old] <= 1'b0;
        hot_q[wm_tlb]  <= 1'b1;
        prpn_q[wm_tlb] <= wm_rpn;
        psn_q[wm_tlb]  <= {nxt, w_cand[CNT_W-1:0]};
        maxc_q         <= w_cand + MAX_W'(1);
      end
      if (pass_start) maxc_q <= MAX_W'(1);
      if (s_visit && s_keep) psn_q[lb_tlb] <= {epoch, cnt_of(s_page)};
    end
  end

  // ---------------- responses ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_rsp <= 1'b0;
      fc_hit <= 1'b0;
      wm_rsp <= 1'b0;
      wm_ok  <= 1'b0;
    end else begin
      fc_rsp <= gnt[G_FC];
      fc_hit <= gnt[G_FC] & f_hit;
      wm_rsp <= gnt[G_WM];
      wm_ok  <= gnt[G_WM] & w_ok;
    end
  end
endmodule

// File: rtl/csg_checker.sv
module csg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       xs_vld,
  input logic       is_vld,
  input logic       fc_vld,
  input logic       wm_vld,
  input logic       fc_rsp,
  input logic       fc_hit,
  input logic       wm_rsp,
  input logic       wm_ok,
  input logic [4:0] gnt,
  input logic [1:0] epoch
);
  logic any_req;
  assign any_req = xs_vld | is_vld | fc_vld | wm_vld;

  assert_fetch_yields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[2] |-> (!xs_vld && !is_vld));

  assert_fetch_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fc_rsp |-> $past(fc_vld && !xs_vld && !is_vld));

  assert_warm_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wm_rsp |-> $past(wm_vld && !fc_vld && !xs_vld && !is_vld));

  assert_hit_has_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fc_hit |-> fc_rsp);

  assert_ok_has_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wm_ok |-> wm_rsp);

  assert_epoch_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(epoch) |-> (epoch == $past(epoch) + 2'd1));

  assert_sweep_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[4] |-> !any_req);

  assert_epoch_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(epoch) |-> $past(!any_req));
endmodule

bind code_seq_guard csg_checker u_csg_checker (
  .clk(clk), .rst_n(rst_n),
  .xs_vld(xs_vld), .is_vld(is_vld), .fc_vld(fc_vld), .wm_vld(wm_vld),
  .fc_rsp(fc_rsp), .fc_hit(fc_hit), .wm_rsp(wm_rsp), .wm_ok(wm_ok),
  .gnt(gnt), .epoch(epoch)
);

// File: tb/test_code_seq_guard.sv
`timescale 1ns/1ps
module test_code_seq_guard;
  localparam int TN = 4, RN = 4, LN = 8, LIMIT = 8, STEPS = 2, BMAX = 15;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       xs_vld = 0, is_vld = 0, fc_vld = 0, wm_vld = 0;
  logic [5:0] xs_rpn = 0, wm_rpn = 0;
  logic [1:0] is_tlb = 0, fc_tlb = 0, wm_tlb = 0;
  logic [2:0] fc_line = 0;
  logic       fc_rsp, fc_hit, wm_rsp, wm_ok;
  logic [1:0] epoch;

  always #2 clk = ~clk;

  code_seq_guard i_code_seq_guard (
    .clk(clk), .rst_n(rst_n),
    .xs_vld(xs_vld), .xs_rpn(xs_rpn), .is_vld(is_vld), .is_tlb(is_tlb),
    .fc_vld(fc_vld), .fc_line(fc_line), .fc_tlb(fc_tlb),
    .wm_vld(wm_vld), .wm_tlb(wm_tlb), .wm_rpn(wm_rpn),
    .fc_rsp(fc_rsp), .fc_hit(fc_hit), .wm_rsp(wm_rsp), .wm_ok(wm_ok),
    .epoch(epoch)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // reference state
  bit m_hot[TN];
  int m_pcyc[TN], m_pcnt[TN], m_rpn[TN], m_rt[RN];
  int m_lcyc[LN], m_lcnt[LN], m_ltlb[LN], m_lrpn[LN];
  int m_ep, m_max, m_budget, m_ptr;
  bit m_sweep;
  bit e_frsp, e_fhit, e_wrsp, e_wok;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < TN; i++) begin m_hot[i] = 0; m_pcyc[i] = 0; m_pcnt[i] = 0; m_rpn[i] = 0; end
    for (int i = 0; i < RN; i++) m_rt[i] = 0;
    for (int i = 0; i < LN; i++) begin m_lcyc[i] = 0; m_lcnt[i] = 0; m_ltlb[i] = 0; m_lrpn[i] = 0; end
    m_ep = 0; m_max = 1; m_budget = 0; m_ptr = 0; m_sweep = 0;
  endfunction

  function automatic void m_chill(int t);
    if (m_pcyc[t] == (m_ep + 1) % 4 && m_pcnt[t] + 1 > m_max) m_max = m_pcnt[t] + 1;
    m_hot[t] = 0;
  endfunction

  function automatic void m_edge(bit xs, int xr, bit is, int it, bit fc, int fl, int ft,
                                 bit wm, int wt, int wr);
    int prev;
    prev = (m_ep + 3) % 4;
    e_frsp = 0; e_fhit = 0; e_wrsp = 0; e_wok = 0;
    if (xs) begin
      int t; t = m_rt[xr % RN];
      if (m_hot[t] && m_rpn[t] == xr) m_chill(t);
    end else if (is) begin
      if (m_hot[it]) m_chill(it);
    end else if (fc) begin
      bit hit;
      hit = m_hot[ft] && m_ltlb[fl] == ft && m_lrpn[fl] == m_rpn[ft] && m_lcnt[fl] == m_pcnt[ft] &&
            (m_lcyc[fl] == m_pcyc[ft] || (m_lcyc[fl] == m_ep && m_pcyc[ft] == prev));
      e_frsp = 1; e_fhit = hit;
      if (!hit) begin
        if (m_hot[ft]) begin
          m_lcyc[fl] = m_pcyc[ft]; m_lcnt[fl] = m_pcnt[ft]; m_ltlb[fl] = ft; m_lrpn[fl] = m_rpn[ft];
        end
        m_budget = (m_budget + STEPS > BMAX) ? BMAX : m_budget + STEPS;
      end
    end else if (wm) begin
      e_wrsp = 1;
      if (m_hot[wt] && m_rpn[wt] == wr) e_wok = 1;
      else begin
        int slot, old, cand; bit vict;
        slot = wr % RN; old = m_rt[slot];
        vict = (old != wt) && m_hot[old];
        cand = m_max;
        if (vict && m_pcyc[old] == (m_ep + 1) % 4 && m_pcnt[old] + 1 > cand) cand = m_pcnt[old] + 1;
        if (cand < LIMIT) begin
          e_wok = 1; m_rt[slot] = wt;
          if (vict) m_hot[old] = 0;
          m_hot[wt] = 1; m_rpn[wt] = wr; m_pcyc[wt] = (m_ep + 1) % 4; m_pcnt[wt] = cand;
          m_max = cand + 1;
        end
      end
    end else if (m_budget > 0) begin
      m_budget--;
      if (!m_sweep) begin
        m_ep = (m_ep + 1) % 4; m_ptr = 0; m_max = 1; m_sweep = 1;
      end else begin
        int p, t;
        p = m_ptr; t = m_ltlb[p];
        if (m_lcyc[p] == prev && m_lcnt[p] != 0) begin
          if (m_hot[t] && m_rpn[t] == m_lrpn[p] && m_pcnt[t] == m_lcnt[p] &&
              (m_pcyc[t] == prev || m_pcyc[t] == m_ep)) begin
            m_lcyc[p] = m_ep; m_pcyc[t] = m_ep;
          end else m_lcnt[p] = 0;
        end
        if (p == LN - 1) begin m_sweep = 0; m_ptr = 0; end else m_ptr = p + 1;
      end
    end
  endfunction

  task automatic drive(input bit xs, input int xr, input bit is, input int it,
                       input bit fc, input int fl, input int ft,
                       input bit wm, input int wt, input int wr, input string tag);
    xs_vld = xs; xs_rpn = 6'(xr); is_vld = is; is_tlb = 2'(it);
    fc_vld = fc; fc_line = 3'(fl); fc_tlb = 2'(ft);
    wm_vld = wm; wm_tlb = 2'(wt); wm_rpn = 6'(wr);
    @(posedge clk);
    m_edge(xs, xr, is, it, fc, fl, ft, wm, wt, wr);
    @(negedge clk);
    check(tag, "fc_rsp", int'(fc_rsp), int'(e_frsp));
    check(tag, "fc_hit", int'(fc_hit), int'(e_fhit));
    check(tag, "wm_rsp", int'(wm_rsp), int'(e_wrsp));
    check(tag, "wm_ok",  int'(wm_ok),  int'(e_wok));
    check(tag, "epoch",  int'(epoch),  m_ep);
  endtask

  task automatic t_fetch(input int l, input int t, input string tag);
    drive(0, 0, 0, 0, 1, l, t, 0, 0, 0, tag);
  endtask
  task automatic t_warm(input int t, input int r, input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 1, t, r, tag);
  endtask
  task automatic t_int(input int t, input string tag);
    drive(0, 0, 1, t, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic t_ext(input int r, input string tag);
    drive(1, r, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic t_idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234_5a5a);
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "epoch after reset", int'(epoch), 0);
    check("R1", "fc_rsp after reset", int'(fc_rsp), 0);

    t_fetch(3, 2, "R1");
    check("R1", "cold fetch hit", int'(fc_hit), 0);

    // R4 fresh number, refill then hit
    t_warm(0, 5, "R4");           check("R4", "warm ok", int'(wm_ok), 1);
    t_fetch(0, 0, "R4");          check("R4", "first fetch hit", int'(fc_hit), 0);
    t_fetch(0, 0, "R10");         check("R10", "refilled fetch hit", int'(fc_hit), 1);
    t_warm(0, 5, "R3");           check("R3", "rewarm ok", int'(wm_ok), 1);
    t_fetch(0, 0, "R3");          check("R3", "hit after rewarm", int'(fc_hit), 1);

    // R5 internal store
    t_int(0, "R5");
    t_fetch(0, 0, "R5");          check("R5", "hit after store", int'(fc_hit), 0);

    // R6 external store
    t_warm(1, 9, "R6");
    t_fetch(1, 1, "R6");
    t_ext(13, "R6");
    t_fetch(1, 1, "R6");          check("R6", "hit after alias store", int'(fc_hit), 1);
    t_ext(9, "R6");
    t_fetch(1, 1, "R6");          check("R6", "hit after matching store", int'(fc_hit), 0);

    // R7 reverse-table takeover
    t_warm(2, 2, "R7");
    t_fetch(2, 2, "R7");
    t_fetch(2, 2, "R7");          check("R7", "hit before takeover", int'(fc_hit), 1);
    t_warm(3, 6, "R7");           check("R7", "takeover ok", int'(wm_ok), 1);
    t_fetch(2, 2, "R7");          check("R7", "hit after takeover", int'(fc_hit), 0);

    // R2 priority
    drive(1, 63, 0, 0, 1, 2, 3, 1, 1, 7, "R2");
    check("R2", "fetch rsp under store", int'(fc_rsp), 0);
    check("R2", "warm rsp under store", int'(wm_rsp), 0);
    drive(0, 0, 0, 0, 1, 2, 3, 1, 1, 7, "R2");
    check("R2", "fetch beats warm", int'(fc_rsp), 1);
    check("R2", "warm loses", int'(wm_rsp), 0);

    // R8 exhaustion (R9 raise checked through the model)
    for (int i = 0; i < 10; i++) begin
      t_warm(i % 4, 32 + i, "R8");
      if (i == 9) check("R8", "warm past count space", int'(wm_ok), 0);
    end

    // R11 / R13 sweep pass
    t_int(3, "R9");
    for (int i = 0; i < 6; i++) t_fetch(0, 3, "R13");
    for (int i = 0; i < 12; i++) t_idle("R13");
    check("R11", "epoch after passes", int'(epoch), 2);
    t_warm(3, 50, "R11");         check("R11", "warm after pass", int'(wm_ok), 1);

    // R12 live line survives passes
    t_int(3, "R12");
    t_warm(0, 40, "R12");         check("R12", "warm ok", int'(wm_ok), 1);
    t_fetch(5, 0, "R12");
    t_fetch(5, 0, "R12");         check("R12", "hit before passes", int'(fc_hit), 1);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 8; i++) t_fetch(6, 3, "R13");
      for (int i = 0; i < 10; i++) t_idle("R12");
    end
    t_fetch(5, 0, "R12");         check("R12", "hit after passes", int'(fc_hit), 1);

    // constrained random
    for (int n = 0; n < 800; n++) begin
      bit xs, is, fc, wm;
      xs = ($urandom % 10) == 0;
      is = ($urandom % 10) == 0;
      fc = ($urandom % 10) < 4;
      wm = ($urandom % 10) < 3;
      drive(xs, $urandom % 16, is, $urandom % 4, fc, $urandom % 8, $urandom % 4,
            wm, $urandom % 4, $urandom % 16, "R10");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule